// File: doc/BRIEF.md
# Double-Word Stream Unpacker

This block moves pairs of samples from a link clock domain into a processing clock domain that runs at exactly twice the link rate, with both clocks derived from one reference. Every link cycle, once the link-side reset is released, the block stores one double-width word together with a single alignment marker bit into a small dual-clock FIFO. Nothing on the link side qualifies the write: each link cycle produces exactly one stored word.

On the processing side, a two-state fill controller holds reads off until the FIFO has built up a cushion of words. It then requests one word on every second processing cycle, which matches the write rate. A splitter turns each word into two consecutive output samples, upper half first. Because the reads follow a free-running phase toggle rather than a handshake, the fill hysteresis is what keeps the output stream free of gaps once it has started.

Top module: `dword_unpacker`

## Requirements
- R1: After the link reset is released, a word is stored on every rising link clock edge. The stored word is `{lnk_sync, lnk_word}`, and there is no qualifying input. Every stored word later appears at the output in the order it was written.
- R2: Each stored word is emitted as two consecutive valid samples. Bits [2*HALF_W-1:HALF_W] come out first and bits [HALF_W-1:0] come out second. Each half is sign-extended from bit HALF_W-1 to OUT_W bits.
- R3: `out_sync` repeats the marker stored with a word on the first (upper-half) sample only. It is 0 on the second (lower-half) sample.
- R4: The controller leaves the idle state only when the read-side word count is at least FILL_NOM + FILL_MARGIN, which is 6 by default.
- R5: The controller returns to idle when the read-side count drops below FILL_NOM, which is 4 by default. When the link clock stops, exactly 2 words remain stored and unread.
- R6: While the controller is active, the phase index toggles every processing cycle and a word is read every second cycle. A read is never issued to an empty FIFO. After the first valid sample, `out_valid` stays 1 on every cycle for as long as the link keeps writing.
- R7: Whenever `out_valid` is 0, `out_data` is 0 and `out_sync` is 0.
- R8: While the reset is held high, `out_valid`, `out_data` and `out_sync` are 0. The controller is idle, with its phase index and read request both at 0.
- R9: While the controller is idle, the phase index is held at 0 and no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lnk_clk | input | 1 | Link-side clock (half the processing rate) |
| lnk_rst | input | 1 | Synchronous active-high reset, link domain |
| lnk_word | input | 2*HALF_W | Sample pair, even sample in the upper half |
| lnk_sync | input | 1 | Alignment marker belonging to the even sample |
| prc_clk | input | 1 | Processing-side clock |
| prc_rst | input | 1 | Synchronous active-high reset, processing domain |
| out_data | output | OUT_W | Sign-extended single sample |
| out_valid | output | 1 | Sample qualifier |
| out_sync | output | 1 | Marker, asserted only with an even sample |

## Verification
The bench stops and restarts the link clock in the middle of a stream, and checks that exactly two words are left behind on each stop. A controller with the wrong exit level, or one that loses a half of the in-flight word, leaves a different residue or breaks the strict sample order when streaming resumes. The counting samples cross from the largest positive value into negative ones, which exposes a splitter that zero-extends or swaps the halves. Markers fall on every fifth word, so a marker that lands on the lower half, or that is lost to a misphased read, shows up as a mismatch. Once output has started, any single-cycle gap in `out_valid` is reported, which catches a read cadence that slips.

// File: rtl/dwu_pkg.sv
package dwu_pkg;

  // fill controller states
  typedef enum logic {
    FILL_IDLE = 1'b0,
    FILL_RUN  = 1'b1
  } fill_state_e;

endpackage

// File: rtl/dwu_gray2bin.sv
module dwu_gray2bin #(
  parameter int W = 5
) (
  input  logic [W-1:0] gray,
  output logic [W-1:0] bin
);

  // each binary bit is the xor of all gray bits at and above it
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign bin[b] = ^gray[W-1:b];
  end

endmodule

// File: rtl/dwu_cdc_fifo.sv
module dwu_cdc_fifo #(
  parameter int DATA_W = 33,
  parameter int ADDR_W = 4
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_pop,
  output logic [ADDR_W:0]   rd_cnt,
  output logic              rd_empty
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;

  logic [DATA_W-1:0] mem [DEPTH];

  // ---------------- write domain ----------------
  logic [PW-1:0] wr_bin, wr_bin_nxt, wr_gray;
  logic [PW-1:0] rd_gray_m1, rd_gray_m2, rd_bin_w;
  logic [PW-1:0] rd_gray;
  logic          wr_full, wr_en;

  dwu_gray2bin #(.W(PW)) u_g2b_wr (
    .gray (rd_gray_m2),
    .bin  (rd_bin_w)
  );

  assign wr_bin_nxt = wr_bin + 1'b1;
  assign wr_full    = (wr_bin - rd_bin_w) == PW'(DEPTH);
  assign wr_en      = ~wr_rst & ~wr_full;

  always_ff @(posedge wr_clk) begin
    if (wr_rst) begin
      wr_bin     <= '0;
      wr_gray    <= '0;
      rd_gray_m1 <= '0;
      rd_gray_m2 <= '0;
    end else begin
      rd_gray_m1 <= rd_gray;
      rd_gray_m2 <= rd_gray_m1;
      if (wr_en) begin
        wr_bin  <= wr_bin_nxt;
        wr_gray <= wr_bin_nxt ^ (wr_bin_nxt >> 1);
      end
    end
  end

  // storage written without reset so it maps onto block RAM
  always_ff @(posedge wr_clk) begin
    if (wr_en) begin
      mem[wr_bin[ADDR_W-1:0]] <= wr_data;
    end
  end

  // ---------------- read domain ----------------
  logic [PW-1:0] rd_bin, rd_bin_nxt;
  logic [PW-1:0] wr_gray_m1, wr_gray_m2, wr_bin_r;

  dwu_gray2bin #(.W(PW)) u_g2b_rd (
    .gray (wr_gray_m2),
    .bin  (wr_bin_r)
  );

  assign rd_cnt     = wr_bin_r - rd_bin;
  assign rd_empty   = (rd_cnt == '0);
  assign rd_pop     = rd_en & ~rd_empty;
  assign rd_bin_nxt = rd_bin + 1'b1;

  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      rd_bin     <= '0;
      rd_gray    <= '0;
      wr_gray_m1 <= '0;
      wr_gray_m2 <= '0;
    end else begin
      wr_gray_m1 <= wr_gray;
      wr_gray_m2 <= wr_gray_m1;
      if (rd_pop) begin
        rd_bin  <= rd_bin_nxt;
        rd_gray <= rd_bin_nxt ^ (rd_bin_nxt >> 1);
      end
    end
  end

  // registered read port
  always_ff @(posedge rd_clk) begin
    if (rd_pop) begin
      rd_data <= mem[rd_bin[ADDR_W-1:0]];
    end
  end

endmodule

// File: rtl/dwu_fill_gate.sv
module dwu_fill_gate
  import dwu_pkg::*;
#(
  parameter int CNT_W       = 5,
  parameter int FILL_NOM    = 4,
  parameter int FILL_MARGIN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] rd_cnt,
  output logic             rd_req,
  output logic             phase_idx,
  output logic             run_st
);

  localparam int ENTER_LVL = FILL_NOM + FILL_MARGIN;

  fill_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= FILL_IDLE;
      phase_idx <= 1'b0;
      rd_req    <= 1'b0;
    end else begin
      case (state)
        FILL_IDLE: begin
          phase_idx <= 1'b0;
          rd_req    <= 1'b0;
          if (rd_cnt >= CNT_W'(ENTER_LVL)) begin
            state <= FILL_RUN;
          end
        end
        default: begin
          phase_idx <= ~phase_idx;
          rd_req    <= ~phase_idx;
          if (rd_cnt < CNT_W'(FILL_NOM)) begin
            state <= FILL_IDLE;
          end
        end
      endcase
    end
  end

  assign run_st = (state == FILL_RUN);

endmodule

// File: rtl/dwu_half_split.sv
module dwu_half_split #(
  parameter int HALF_W = 16,
  parameter int OUT_W  = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pop,
  input  logic [2*HALF_W-1:0] word,
  input  logic                word_sync,
  output logic [OUT_W-1:0]    out_data,
  output logic                out_valid,
  output logic                out_sync
);

  localparam int EXT_W = OUT_W - HALF_W;

  logic              hi_turn, lo_turn;
  logic [HALF_W-1:0] hi_half, lo_half;
  logic [OUT_W-1:0]  hi_ext, lo_ext;

  assign hi_half = word[2*HALF_W-1:HALF_W];
  assign lo_half = word[HALF_W-1:0];

  if (EXT_W > 0) begin : g_ext
    assign hi_ext = {{EXT_W{hi_half[HALF_W-1]}}, hi_half};
    assign lo_ext = {{EXT_W{lo_half[HALF_W-1]}}, lo_half};
  end else begin : g_same
    assign hi_ext = hi_half;
    assign lo_ext = lo_half;
  end

  // first cycle after a pop: upper half; second cycle: lower half
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_turn <= 1'b0;
      lo_turn <= 1'b0;
    end else begin
      hi_turn <= pop;
      lo_turn <= hi_turn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data  <= '0;
      out_valid <= 1'b0;
      out_sync  <= 1'b0;
    end else if (hi_turn) begin
      out_data  <= hi_ext;
      out_valid <= 1'b1;
      out_sync  <= word_sync;
    end else if (lo_turn) begin
      out_data  <= lo_ext;
      out_valid <= 1'b1;
      out_sync  <= 1'b0;
    end else begin
      out_data  <= '0;
      out_valid <= 1'b0;
      out_sync  <= 1'b0;
    end
  end

endmodule

// File: rtl/dword_unpacker.sv
module dword_unpacker #(
  parameter int HALF_W      = 16,
  parameter int OUT_W       = 20,
  parameter int ADDR_W      = 4,
  parameter int FILL_NOM    = 4,
  parameter int FILL_MARGIN = 2
) (
  input  logic                lnk_clk,
  input  logic                lnk_rst,
  input  logic [2*HALF_W-1:0] lnk_word,
  input  logic                lnk_sync,
  input  logic                prc_clk,
  input  logic                prc_rst,
  output logic [OUT_W-1:0]    out_data,
  output logic                out_valid,
  output logic                out_sync
);

  localparam int WORD_W = 2 * HALF_W;
  localparam int ENTRY_W = WORD_W + 1;
  localparam int CNT_W = ADDR_W + 1;

  logic [ENTRY_W-1:0] rd_entry;
  logic               rd_pop;
  logic [CNT_W-1:0]   rd_cnt;
  logic               rd_empty;
  logic               rd_req;
  logic               phase_idx;
  logic               run_st;

  dwu_cdc_fifo #(
    .DATA_W (ENTRY_W),
    .ADDR_W (ADDR_W)
  ) u_fifo (
    .wr_clk   (lnk_clk),
    .wr_rst   (lnk_rst),
    .wr_data  ({lnk_sync, lnk_word}),
    .rd_clk   (prc_clk),
    .rd_rst   (prc_rst),
    .rd_en    (rd_req),
    .rd_data  (rd_entry),
    .rd_pop   (rd_pop),
    .rd_cnt   (rd_cnt),
    .rd_empty (rd_empty)
  );

  dwu_fill_gate #(
    .CNT_W       (CNT_W),
    .FILL_NOM    (FILL_NOM),
    .FILL_MARGIN (FILL_MARGIN)
  ) u_gate (
    .clk       (prc_clk),
    .rst       (prc_rst),
    .rd_cnt    (rd_cnt),
    .rd_req    (rd_req),
    .phase_idx (phase_idx),
    .run_st    (run_st)
  );

  dwu_half_split #(
    .HALF_W (HALF_W),
    .OUT_W  (OUT_W)
  ) u_split (
    .clk       (prc_clk),
    .rst       (prc_rst),
    .pop       (rd_pop),
    .word      (rd_entry[WORD_W-1:0]),
    .word_sync (rd_entry[WORD_W]),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_sync  (out_sync)
  );

endmodule

// File: rtl/dwu_checker.sv
module dwu_checker #(
  parameter int CNT_W       = 5,
  parameter int OUT_W       = 20,
  parameter int FILL_NOM    = 4,
  parameter int FILL_MARGIN = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             run_st,
  input logic             phase_idx,
  input logic             rd_req,
  input logic [CNT_W-1:0] rd_cnt,
  input logic             rd_empty,
  input logic [OUT_W-1:0] out_data,
  input logic             out_valid,
  input logic             out_sync
);

  // R4
  enter_level_chk: assert property (@(posedge clk) disable iff (rst)
    (run_st && !$past(run_st)) |-> ($past(rd_cnt) >= CNT_W'(FILL_NOM + FILL_MARGIN)));

  // R5
  exit_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_st && $past(run_st)) |-> ($past(rd_cnt) < CNT_W'(FILL_NOM)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_st && !$past(run_st)) |-> (!phase_idx && !rd_req));

  // R6
  phase_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (run_st && $past(run_st)) |-> (phase_idx != $past(phase_idx)));

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> !rd_empty);

  // R7
  quiet_out_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_data == '0 && !out_sync));

  // R3
  sync_upper_chk: assert property (@(posedge clk) disable iff (rst)
    out_sync |=> (out_valid && !out_sync));

endmodule

bind dword_unpacker dwu_checker #(
  .CNT_W       (CNT_W),
  .OUT_W       (OUT_W),
  .FILL_NOM    (FILL_NOM),
  .FILL_MARGIN (FILL_MARGIN)
) u_chk (
  .clk       (prc_clk),
  .rst       (prc_rst),
  .run_st    (run_st),
  .phase_idx (phase_idx),
  .rd_req    (rd_req),
  .rd_cnt    (rd_cnt),
  .rd_empty  (rd_empty),
  .out_data  (out_data),
  .out_valid (out_valid),
  .out_sync  (out_sync)
);

// File: tb/tb_dword_unpacker.sv
module tb_dword_unpacker;

  localparam int HW = 16;
  localparam int OW = 20;

  typedef struct {
    logic [OW-1:0] data;
    logic          sync;
  } exp_t;

  logic            lnk_clk, lnk_rst, lnk_sync, prc_clk, prc_rst;
  logic [2*HW-1:0] lnk_word;
  logic [OW-1:0]   out_data;
  logic            out_valid, out_sync;

  int   vectors = 0;
  int   fails = 0;
  bit   done = 0;
  bit   lnk_run = 1;
  bit   stream_on = 0;
  bit   armed = 0;
  bit   seen = 0;
  int   k = 0;
  int   wr_words = 0;
  int   start_words = 0;
  int   first_words = 0;
  exp_t exp_q[$];

  dword_unpacker #(.HALF_W(HW), .OUT_W(OW)) dut (
    .lnk_clk   (lnk_clk),
    .lnk_rst   (lnk_rst),
    .lnk_word  (lnk_word),
    .lnk_sync  (lnk_sync),
    .prc_clk   (prc_clk),
    .prc_rst   (prc_rst),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_sync  (out_sync)
  );

  // 100 MHz processing clock
  initial begin
    prc_clk = 1'b0;
    forever #5 prc_clk = ~prc_clk;
  end

  // link clock at half rate, offset in phase, gateable
  initial begin
    lnk_clk = 1'b0;
    #3;
    forever #10 lnk_clk = lnk_run ? ~lnk_clk : 1'b0;
  end

  function automatic logic [HW-1:0] smp(input int n);
    return HW'(32'h7FF0 + n);
  endfunction

  function automatic logic [OW-1:0] sext(input logic [HW-1:0] v);
    return {{(OW-HW){v[HW-1]}}, v};
  endfunction

  task automatic drive_word(input int n);
    lnk_word = {smp(2*n), smp(2*n+1)};
    lnk_sync = (n % 5 == 0);
  endtask

  // driver: each written word yields two expected samples (R1, R2, R3)
  task automatic push_word(input int n);
    exp_t e;
    e.data = sext(smp(2*n));
    e.sync = (n % 5 == 0);
    exp_q.push_back(e);
    e.data = sext(smp(2*n+1));
    e.sync = 1'b0;
    exp_q.push_back(e);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always begin
    @(posedge lnk_clk);
    if (!lnk_rst) begin
      push_word(k);
      wr_words++;
      @(negedge lnk_clk);
      k++;
      drive_word(k);
    end
  end

  // monitor / scoreboard
  always @(negedge prc_clk) begin
    if (!prc_rst) begin
      if (!stream_on) armed = 1'b0;
      if (out_valid) begin
        if (!seen) begin
          seen = 1'b1;
          first_words = wr_words - start_words;
        end
        if (stream_on) armed = 1'b1;
        if (exp_q.size() == 0) begin
          check(1'b0, "R1", "unexpected sample", longint'(out_data), 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          // R2 order and sign extension
          check(out_data == e.data, "R2", "sample value", longint'(out_data), longint'(e.data));
          // R3 marker only on upper half
          check(out_sync == e.sync, "R3", "sync flag", longint'(out_sync), longint'(e.sync));
        end
      end else begin
        // R7 quiet outputs
        check(out_data == '0 && !out_sync, "R7", "idle outputs", longint'(out_data), 0);
        // R6 no gap once streaming
        check(!armed, "R6", "valid gap", 0, 1);
      end
    end
  end

  initial begin
    lnk_rst = 1'b1;
    prc_rst = 1'b1;
    drive_word(0);
    repeat (6) @(negedge prc_clk);
    // R8 reset state
    check(!out_valid, "R8", "valid in reset", longint'(out_valid), 0);
    check(out_data == '0 && !out_sync, "R8", "data in reset", longint'(out_data), 0);
    prc_rst = 1'b0;
    lnk_rst = 1'b0;
    stream_on = 1'b1;

    repeat (400) @(negedge prc_clk);
    check(seen, "R1", "stream started", longint'(seen), 1);
    // R4 entry needs at least six stored words
    check(first_words >= 6, "R4", "words before first valid", first_words, 6);
    check(exp_q.size() <= 32, "R6", "backlog bounded", exp_q.size(), 32);

    // stop the link: controller must drain down to two words
    stream_on = 1'b0;
    lnk_run = 1'b0;
    repeat (60) @(negedge prc_clk);
    check(!out_valid, "R5", "valid after drain", longint'(out_valid), 0);
    check(exp_q.size() == 4, "R5", "residue samples", exp_q.size(), 4);

    // restart: refill from residue of two, order preserved
    start_words = wr_words;
    seen = 1'b0;
    stream_on = 1'b1;
    lnk_run = 1'b1;
    repeat (400) @(negedge prc_clk);
    check(seen, "R1", "stream resumed", longint'(seen), 1);
    check(first_words >= 4, "R4", "new words before refill", first_words, 4);

    stream_on = 1'b0;
    lnk_run = 1'b0;
    repeat (60) @(negedge prc_clk);
    check(!out_valid, "R5", "valid after second drain", longint'(out_valid), 0);
    check(exp_q.size() == 4, "R5", "second residue", exp_q.size(), 4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule